// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a 16-bit processor core that carries out the hardware steps of taking an interrupt and of coming back from one. It can take four kinds of request. An exception request carries its own type number; divide by zero uses 0, single step 1, breakpoint 3 and overflow 4, and software traps use any type. A non-maskable request always uses type 2. A maskable request obtains its type from the interrupting device during a one-cycle acknowledge. A return command restores the interrupted context.

To enter, the block saves the current flags word, code segment and instruction pointer on a memory stack. It then clears the interrupt-enable flag (bit 9 of the flags word) in the flags it hands back. Next it reads a two-word vector from a table at address zero, at the type number times four. It presents the new segment, pointer and flags with a one-cycle strobe. To return, it pops the three words in reverse order and presents them the same way. Memory is reached one 16-bit word at a time through a request/ready handshake. The block keeps its own byte-addressed stack pointer and needs no other stack arithmetic.

States: IDLE (waits and arbitrates), ACK (acknowledge cycle for a maskable request), PUSH_F, PUSH_C and PUSH_I (the three stack writes), CLR_IF (clears the enable flag), VEC_LO and VEC_HI (the two table reads), POP_I, POP_C and POP_F (the three stack reads), and LOAD (the strobe). The transitions are:
- IDLE goes to PUSH_F on an exception or non-maskable request, to ACK on an enabled maskable request, and to POP_I on a return.
- ACK goes to PUSH_F.
- Each memory state advances only on a completed transfer: PUSH_F to PUSH_C to PUSH_I to CLR_IF, and VEC_LO to VEC_HI to LOAD.
- CLR_IF goes to VEC_LO.
- POP_I goes to POP_C, then to POP_F, then to LOAD.
- LOAD returns to IDLE.

Top module: `intr_seq`

## Requirements
- R1: After reset, busy, jump_vld, inta and mem_req are low and sp equals the SP_RESET parameter (0x8000 by default).
- R2: Each memory access moves one 16-bit word. mem_req, mem_we, mem_addr and mem_wdata stay unchanged until a clock edge at which mem_rdy is high, and that edge completes the access.
- R3: Requests are sampled only in IDLE. When several are present, the priority is exception, then non-maskable, then maskable, then return.
- R4: A maskable request is taken only when cur_flags bit 9 is 1. Exception and non-maskable requests are taken whatever that bit is.
- R5: A maskable entry raises inta for exactly one cycle, and the type number is inta_type sampled in that cycle.
- R6: A non-maskable entry uses type 2. An exception entry uses exc_type.
- R7: Entry writes the flags to sp-2, the code segment to sp-4 and the pointer to sp-6, in that order. sp drops by 2 before each write and ends 6 lower.
- R8: The vector reads are type*4 (the offset, which becomes new_ip) and then type*4+2 (the segment, which becomes new_cs). new_ip and new_cs change together, only after the second read.
- R9: After the writes and before the table reads, new_flags becomes the saved flags with bit 9 cleared. That value is still present at the strobe.
- R10: Return reads the pointer at sp, the segment at sp+2 and the flags at sp+4, adding 2 to sp after each read. The strobe then presents all three values, with bit 9 restored.
- R11: busy is high from the cycle after acceptance through the jump_vld cycle and low in the cycle after it. jump_vld lasts one cycle. Requests present while busy have no effect.
- R12: With mem_rdy high in the cycle after each request, jump_vld appears 10 clock edges after acceptance for an exception or non-maskable entry, 11 for a maskable entry and 6 for a return, counting the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception or software trap request |
| exc_type | input | TYPE_W | Type number of the exception |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request |
| inta | output | 1 | Acknowledge strobe for the maskable request |
| inta_type | input | TYPE_W | Type number from the device, sampled during inta |
| iret_req | input | 1 | Return command |
| cur_flags | input | DW | Flags word of the running code |
| cur_cs | input | DW | Code segment of the running code |
| cur_ip | input | DW | Instruction pointer of the running code |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Access completes at this clock edge |
| busy | output | 1 | Sequence in progress |
| jump_vld | output | 1 | One-cycle strobe: new context valid |
| new_flags | output | DW | Flags word to load |
| new_cs | output | DW | Code segment to load |
| new_ip | output | DW | Instruction pointer to load |
| sp | output | AW | Stack pointer |

## Verification
Every result is due a fixed number of edges after the accepting edge. The bench memory raises mem_rdy one cycle after each request in the main runs. With that memory the strobe comes on the 10th edge for an exception or non-maskable entry, the 11th for a maskable entry and the 6th for a return. The bench drives requests on the falling edge and counts rising edges until it sees jump_vld at a falling edge. It compares that count with the due value, and then reads new_ip, new_cs, new_flags and sp in that same sample. It checks stack contents, access order and inta pulses from records kept at each completed transfer. Runs with two wait cycles check only the values, not the timing.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_F,
        ST_PUSH_C,
        ST_PUSH_I,
        ST_CLR_IF,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_POP_I,
        ST_POP_C,
        ST_POP_F,
        ST_LOAD
    } seq_state_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXC,
        SRC_NMI,
        SRC_INTR,
        SRC_RET
    } src_t;

    localparam int IF_BIT   = 9;
    localparam int NMI_CODE = 2;

endpackage

// File: rtl/intr_arb.sv
module intr_arb
    import intr_seq_pkg::*;
(
    input  logic exc_req,
    input  logic nmi_req,
    input  logic intr_req,
    input  logic if_en,
    input  logic iret_req,
    output src_t pick
);

    // fixed priority: exception, non-maskable, enabled maskable, return (R3, R4)
    always_comb begin
        if (exc_req)                pick = SRC_EXC;
        else if (nmi_req)           pick = SRC_NMI;
        else if (intr_req && if_en) pick = SRC_INTR;
        else if (iret_req)          pick = SRC_RET;
        else                        pick = SRC_NONE;
    end

endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
    import intr_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TYPE_W = 8,
    parameter logic [AW-1:0] SP_RESET = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_t              pick,
    input  logic [TYPE_W-1:0] exc_type,
    input  logic [TYPE_W-1:0] inta_type,
    input  logic [DW-1:0]     cur_flags,
    input  logic [DW-1:0]     cur_cs,
    input  logic [DW-1:0]     cur_ip,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_rdy,
    output logic              inta,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              busy,
    output logic              jump_vld,
    output logic [DW-1:0]     new_flags,
    output logic [DW-1:0]     new_cs,
    output logic [DW-1:0]     new_ip,
    output logic [AW-1:0]     sp
);

    localparam logic [AW-1:0] STEP      = AW'(DW / 8);
    localparam logic [AW-1:0] VEC_BYTES = AW'(2 * (DW / 8));
    localparam logic [AW-1:0] TBL_END   = AW'((1 << TYPE_W) * 2 * (DW / 8));

    seq_state_t        state, nxt;
    logic [TYPE_W-1:0] vec_type;
    logic [DW-1:0]     sv_flags, sv_cs, sv_ip, tmp_ip, tmp_cs;
    logic              is_ret;
    logic              xfer;
    logic [AW-1:0]     vec_base;

    assign xfer     = mem_req && mem_rdy;
    assign vec_base = AW'(vec_type) * VEC_BYTES;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                unique case (pick)
                    SRC_EXC, SRC_NMI: nxt = ST_PUSH_F;
                    SRC_INTR:         nxt = ST_ACK;
                    SRC_RET:          nxt = ST_POP_I;
                    default:          nxt = ST_IDLE;
                endcase
            end
            ST_ACK:    nxt = ST_PUSH_F;
            ST_PUSH_F: if (xfer) nxt = ST_PUSH_C;
            ST_PUSH_C: if (xfer) nxt = ST_PUSH_I;
            ST_PUSH_I: if (xfer) nxt = ST_CLR_IF;
            ST_CLR_IF: nxt = ST_VEC_LO;
            ST_VEC_LO: if (xfer) nxt = ST_VEC_HI;
            ST_VEC_HI: if (xfer) nxt = ST_LOAD;
            ST_POP_I:  if (xfer) nxt = ST_POP_C;
            ST_POP_C:  if (xfer) nxt = ST_POP_F;
            ST_POP_F:  if (xfer) nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp        <= SP_RESET;
            vec_type  <= '0;
            sv_flags  <= '0;
            sv_cs     <= '0;
            sv_ip     <= '0;
            tmp_ip    <= '0;
            tmp_cs    <= '0;
            new_flags <= '0;
            new_cs    <= '0;
            new_ip    <= '0;
            is_ret    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pick != SRC_NONE) begin
                        sv_flags <= cur_flags;
                        sv_cs    <= cur_cs;
                        sv_ip    <= cur_ip;
                        is_ret   <= (pick == SRC_RET);
                        vec_type <= (pick == SRC_EXC) ? exc_type : TYPE_W'(NMI_CODE);
                    end
                end
                ST_ACK: vec_type <= inta_type;
                ST_PUSH_F, ST_PUSH_C, ST_PUSH_I: if (xfer) sp <= sp - STEP;
                ST_CLR_IF: begin
                    new_flags         <= sv_flags;
                    new_flags[IF_BIT] <= 1'b0;
                end
                ST_VEC_LO: if (xfer) tmp_ip <= mem_rdata;
                ST_VEC_HI: begin
                    if (xfer) begin
                        new_ip <= tmp_ip;
                        new_cs <= mem_rdata;
                    end
                end
                ST_POP_I: begin
                    if (xfer) begin
                        tmp_ip <= mem_rdata;
                        sp     <= sp + STEP;
                    end
                end
                ST_POP_C: begin
                    if (xfer) begin
                        tmp_cs <= mem_rdata;
                        sp     <= sp + STEP;
                    end
                end
                ST_POP_F: begin
                    if (xfer) begin
                        new_ip    <= tmp_ip;
                        new_cs    <= tmp_cs;
                        new_flags <= mem_rdata;
                        sp        <= sp + STEP;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_F: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp - STEP; mem_wdata = sv_flags; end
            ST_PUSH_C: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp - STEP; mem_wdata = sv_cs;    end
            ST_PUSH_I: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp - STEP; mem_wdata = sv_ip;    end
            ST_VEC_LO: begin mem_req = 1'b1; mem_addr = vec_base;        end
            ST_VEC_HI: begin mem_req = 1'b1; mem_addr = vec_base + STEP; end
            ST_POP_I, ST_POP_C, ST_POP_F: begin mem_req = 1'b1; mem_addr = sp; end
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign jump_vld = (state == ST_LOAD);
    assign inta     = (state == ST_ACK);

    // R2: a pending access holds its request until ready
    assert_hold_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: each completed write leaves sp two lower
    assert_push_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_rdy) |=> (sp == $past(sp) - STEP));

    // R10: each completed pop leaves sp two higher
    assert_pop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_rdy && is_ret) |=> (sp == $past(sp) + STEP));

    // R8: table reads stay inside the vector table and are word aligned
    assert_table_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !is_ret) |-> (mem_addr < TBL_END && mem_addr[0] == 1'b0));

    // R9: an entry never hands back an enabled flag
    assert_if_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_vld && !is_ret) |-> !new_flags[IF_BIT]);

    // R5: acknowledge is a single-cycle pulse
    assert_inta_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> !inta);

    // R11: the strobe is one cycle and ends the busy period
    assert_strobe_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        jump_vld |=> (!busy && !jump_vld));

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TYPE_W = 8,
    parameter logic [AW-1:0] SP_RESET = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [TYPE_W-1:0] exc_type,
    input  logic              nmi_req,
    input  logic              intr_req,
    output logic              inta,
    input  logic [TYPE_W-1:0] inta_type,
    input  logic              iret_req,
    input  logic [DW-1:0]     cur_flags,
    input  logic [DW-1:0]     cur_cs,
    input  logic [DW-1:0]     cur_ip,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              jump_vld,
    output logic [DW-1:0]     new_flags,
    output logic [DW-1:0]     new_cs,
    output logic [DW-1:0]     new_ip,
    output logic [AW-1:0]     sp
);

    src_t pick;

    intr_arb u_arb (
        .exc_req  (exc_req),
        .nmi_req  (nmi_req),
        .intr_req (intr_req),
        .if_en    (cur_flags[IF_BIT]),
        .iret_req (iret_req),
        .pick     (pick)
    );

    intr_fsm #(
        .AW       (AW),
        .DW       (DW),
        .TYPE_W   (TYPE_W),
        .SP_RESET (SP_RESET)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick      (pick),
        .exc_type  (exc_type),
        .inta_type (inta_type),
        .cur_flags (cur_flags),
        .cur_cs    (cur_cs),
        .cur_ip    (cur_ip),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .inta      (inta),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .jump_vld  (jump_vld),
        .new_flags (new_flags),
        .new_cs    (new_cs),
        .new_ip    (new_ip),
        .sp        (sp)
    );

endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, nmi_req = 1'b0, intr_req = 1'b0, iret_req = 1'b0;
    logic [7:0]  exc_type = '0, inta_type = '0;
    logic [15:0] cur_flags = '0, cur_cs = '0, cur_ip = '0;
    logic        inta, mem_req, mem_we, busy, jump_vld;
    logic [15:0] mem_addr, mem_wdata, new_flags, new_cs, new_ip, sp;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;

    int checks = 0;
    int failures = 0;
    int wait_n = 0;
    int wcnt = 0;
    int ack_n = 0;
    bit finished = 1'b0;
    logic [15:0] mem [int];
    int wr_q[$];
    int rd_q[$];

    always #4 clk = ~clk;

    intr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .nmi_req(nmi_req), .intr_req(intr_req), .inta(inta), .inta_type(inta_type),
        .iret_req(iret_req), .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .jump_vld(jump_vld),
        .new_flags(new_flags), .new_cs(new_cs), .new_ip(new_ip), .sp(sp)
    );

    function automatic logic [15:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 16'hDEAD;
    endfunction

    function automatic logic [15:0] vip(input int t);
        return 16'(t * 3 + 16'h0100);
    endfunction

    function automatic logic [15:0] vcs(input int t);
        return 16'hF000 ^ 16'(t << 4);
    endfunction

    // memory model: completed transfers recorded at the rising edge
    always @(posedge clk) begin
        if (mem_req && mem_rdy) begin
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                wr_q.push_back(int'(mem_addr));
            end else begin
                rd_q.push_back(int'(mem_addr));
            end
        end
        if (inta) ack_n++;
    end

    // ready raised after wait_n idle falling edges
    always @(negedge clk) begin
        if (mem_rdy) begin
            mem_rdy = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_n) begin
                mem_rdy = 1'b1;
                mem_rdata = rd(int'(mem_addr));
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drop_reqs();
        exc_req = 1'b0; nmi_req = 1'b0; intr_req = 1'b0; iret_req = 1'b0;
    endtask

    // reqs bits: 0 exception, 1 non-maskable, 2 maskable, 3 return
    task automatic run_entry(input logic [3:0] reqs, input logic [7:0] et, input logic [7:0] at,
                             input logic [7:0] exp_t, input bit exp_ack, input logic [15:0] fl,
                             input logic [15:0] cs, input logic [15:0] ip, input bit pest);
        int edges;
        int sp0;
        int ack0;
        @(negedge clk);
        sp0 = int'(sp);
        ack0 = ack_n;
        wr_q.delete();
        rd_q.delete();
        cur_flags = fl; cur_cs = cs; cur_ip = ip;
        exc_type = et; inta_type = at;
        exc_req = reqs[0]; nmi_req = reqs[1]; intr_req = reqs[2]; iret_req = reqs[3];
        edges = 0;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (busy) begin
                drop_reqs();
                if (pest) nmi_req = 1'b1;
            end
            if (jump_vld) break;
            if (edges > 400) break;
        end
        nmi_req = 1'b0;
        chk(jump_vld == 1'b1, "R11", int'(jump_vld), 1, "entry strobe");
        chk(new_ip == vip(exp_t), "R8", int'(new_ip), int'(vip(exp_t)), "new_ip from table");
        chk(new_cs == vcs(exp_t), "R8", int'(new_cs), int'(vcs(exp_t)), "new_cs from table");
        chk(new_flags == (fl & 16'hFDFF), "R9", int'(new_flags), int'(fl & 16'hFDFF), "flags with enable cleared");
        chk(int'(sp) == ((sp0 - 6) & 16'hFFFF), "R7", int'(sp), (sp0 - 6) & 16'hFFFF, "sp after pushes");
        chk(wr_q.size() == 3 && wr_q[0] == sp0 - 2 && wr_q[1] == sp0 - 4 && wr_q[2] == sp0 - 6,
            "R7", wr_q.size(), 3, "push address order");
        chk(rd(sp0 - 2) == fl && rd(sp0 - 4) == cs && rd(sp0 - 6) == ip,
            "R7", int'(rd(sp0 - 6)), int'(ip), "stacked words");
        chk(rd_q.size() == 2 && rd_q[0] == int'(exp_t) * 4 && rd_q[1] == int'(exp_t) * 4 + 2,
            "R8", (rd_q.size() > 0) ? rd_q[0] : -1, int'(exp_t) * 4, "vector read addresses");
        chk((ack_n - ack0) == (exp_ack ? 1 : 0), (exp_ack ? "R5" : "R3"), ack_n - ack0, exp_ack ? 1 : 0, "acknowledge pulses");
        if (wait_n == 0)
            chk(edges == (exp_ack ? 11 : 10), "R12", edges, exp_ack ? 11 : 10, "entry latency");
        @(negedge clk);
        chk(busy == 1'b0 && jump_vld == 1'b0, "R11", int'(busy), 0, "busy after strobe");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && int'(sp) == ((sp0 - 6) & 16'hFFFF), "R11", int'(sp), (sp0 - 6) & 16'hFFFF, "no late request taken");
    endtask

    task automatic run_ret(input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip);
        int edges;
        int sp0;
        @(negedge clk);
        sp0 = int'(sp);
        rd_q.delete();
        cur_flags = 16'h0000;
        iret_req = 1'b1;
        edges = 0;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (busy) drop_reqs();
            if (jump_vld) break;
            if (edges > 400) break;
        end
        chk(new_ip == ip && new_cs == cs, "R10", int'(new_ip), int'(ip), "restored pointer");
        chk(new_flags == fl, "R10", int'(new_flags), int'(fl), "restored flags");
        chk(int'(sp) == sp0 + 6, "R10", int'(sp), sp0 + 6, "sp after pops");
        chk(rd_q.size() == 3 && rd_q[0] == sp0 && rd_q[1] == sp0 + 2 && rd_q[2] == sp0 + 4,
            "R10", rd_q.size(), 3, "pop addresses");
        if (wait_n == 0)
            chk(edges == 6, "R12", edges, 6, "return latency");
        @(negedge clk);
    endtask

    initial begin
        for (int t = 0; t < 256; t++) begin
            mem[t * 4] = vip(t);
            mem[t * 4 + 2] = vcs(t);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && jump_vld == 1'b0 && inta == 1'b0 && mem_req == 1'b0, "R1", int'(busy), 0, "outputs idle in reset");
        chk(sp == 16'h8000, "R1", int'(sp), 16'h8000, "reset sp");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0 && sp == 16'h8000, "R1", int'(sp), 16'h8000, "idle after reset");

        // R6, R4: every exception type, enable flag alternating
        for (int t = 0; t < 256; t++) begin
            logic [15:0] fl;
            fl = 16'((t << 4) | 16'h0002) | ((t % 2) == 1 ? 16'h0200 : 16'h0000);
            run_entry(4'b0001, 8'(t), 8'h00, 8'(t), 1'b0, fl, 16'(16'h1000 + t), 16'(16'h4000 ^ t), 1'b0);
            run_ret(fl, 16'(16'h1000 + t), 16'(16'h4000 ^ t));
        end

        // R6, R4: non-maskable with enable clear uses type 2
        run_entry(4'b0010, 8'h55, 8'h77, 8'd2, 1'b0, 16'h0046, 16'h2222, 16'h3333, 1'b0);
        run_ret(16'h0046, 16'h2222, 16'h3333);

        // R5, R2: maskable sweep with two wait cycles per access
        wait_n = 2;
        for (int t = 0; t < 256; t += 17) begin
            run_entry(4'b0100, 8'hFF, 8'(t), 8'(t), 1'b1, 16'h0202, 16'(16'h5000 + t), 16'(t * 7), 1'b0);
            run_ret(16'h0202, 16'(16'h5000 + t), 16'(t * 7));
        end
        wait_n = 0;
        run_entry(4'b0100, 8'hFF, 8'hC8, 8'hC8, 1'b1, 16'h0200, 16'h6000, 16'h0123, 1'b0);
        run_ret(16'h0200, 16'h6000, 16'h0123);

        // R4: maskable ignored while the enable bit is clear
        begin
            bit quiet;
            quiet = 1'b1;
            @(negedge clk);
            cur_flags = 16'h0000;
            intr_req = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (busy || mem_req || inta) quiet = 1'b0;
            end
            intr_req = 1'b0;
            chk(quiet && sp == 16'h8000, "R4", int'(busy), 0, "masked request ignored");
        end

        // R3: priority among simultaneous requests
        run_entry(4'b1111, 8'h21, 8'h90, 8'h21, 1'b0, 16'h0200, 16'h7000, 16'h0010, 1'b0);
        run_ret(16'h0200, 16'h7000, 16'h0010);
        run_entry(4'b1110, 8'h21, 8'h90, 8'd2, 1'b0, 16'h0200, 16'h7100, 16'h0020, 1'b0);
        run_ret(16'h0200, 16'h7100, 16'h0020);
        run_entry(4'b1100, 8'h21, 8'h90, 8'h90, 1'b1, 16'h0200, 16'h7200, 16'h0030, 1'b0);
        run_ret(16'h0200, 16'h7200, 16'h0030);

        // R11: a non-maskable request held while busy has no effect
        run_entry(4'b0001, 8'h03, 8'h00, 8'h03, 1'b0, 16'h0000, 16'h7300, 16'h0040, 1'b1);
        run_ret(16'h0000, 16'h7300, 16'h0040);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 180000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule